// File: doc/BRIEF.md
# Burst Address Expander

This block turns one burst command of a memory-mapped address channel into the sequence of per-transfer addresses that the burst covers. A command carries a start address, a burst type, a length field, a size field and a transaction ID. It arrives through a valid/ready handshake. The block then presents one beat per transfer on an output stream with the same fields and its own valid/ready handshake. A downstream single-beat memory port or a width converter can use each beat directly.

The command is captured in registers when it is accepted, so the upstream side may change its inputs on the next cycle. Beats are released only when the consumer is ready. The next command is taken in the same cycle that the final beat of the current burst is consumed, so back-to-back bursts leave no idle cycle. Fixed, incrementing and wrapping address sequences are supported. A wrapping command with an illegal length or a misaligned start is stepped as an incrementing burst and is flagged on every beat it produces.

Top module: `axi_burst_expander`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: A command is accepted on a clock edge where in_valid and in_ready are both high. From the next cycle, out_valid is high and the first beat carries the accepted start address.
- R3: A command with length field L produces exactly L+1 beats. out_last is high on the final beat only, and no further beat follows it.
- R4: Burst type code 0 (fixed): every beat carries the start address.
- R5: Burst type code 1 (incrementing): beat i carries start + i·2^size, modulo 2^32. Code 3 is stepped the same way.
- R6: Burst type code 2 (wrapping), legal when L is 1, 3, 7 or 15 and the start is a multiple of 2^size. The window is W = (L+1)·2^size bytes. Beat i carries floor(start/W)·W + ((start mod W) + i·2^size) mod W.
- R7: A wrapping command that breaks either legality rule is stepped as in R5. out_wrap_err is high on all of its beats. out_wrap_err is low on beats of every other command.
- R8: While out_valid is high and out_ready is low, the presented beat (address, last, ID) holds unchanged until it is consumed. No beat is dropped or repeated.
- R9: in_ready is high only when no burst is in progress, or in the cycle when the final beat is being consumed. A command waiting during a burst is accepted on exactly the edge that consumes the final beat.
- R10: ID, burst type, length and size are presented unchanged on every beat of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Command can be taken this cycle |
| in_addr | input | 32 | Burst start address |
| in_burst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping, 3 treated as incrementing |
| in_len | input | 8 | Beats minus one |
| in_size | input | 3 | log2 of bytes per beat |
| in_id | input | 4 | Transaction ID |
| out_valid | output | 1 | Beat presented |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_addr | output | 32 | Address of this beat |
| out_burst | output | 2 | Copied burst type |
| out_len | output | 8 | Copied length field |
| out_size | output | 3 | Copied size field |
| out_id | output | 4 | Copied transaction ID |
| out_last | output | 1 | Final beat of the burst |
| out_wrap_err | output | 1 | Beat belongs to an illegal wrapping command |

## Verification
The first beat is due one clock edge after the accepting edge. Each later beat is due one edge after the previous beat is consumed. in_ready responds in the same cycle to out_ready on the final beat, with no register in that path. The bench drives out_ready on the falling edge and all command inputs just after the rising edge, then samples 1 to 2 ns after the falling edge. Every handshake it counts is therefore the one that the next rising edge will complete. For R9, the bench compares the cycle number at which a waiting command is accepted with the cycle number of the previous burst's final-beat handshake; the two must be equal.

// File: rtl/burst_pkg.sv
// Shared types for the burst address expander.
// Assumes burst type codes 0 fixed, 1 incrementing, 2 wrapping, 3 reserved.
package burst_pkg;
    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    // How the address advances after each consumed beat.
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_LINEAR = 2'd1,
        STEP_WRAP   = 2'd2
    } step_e;
endpackage

// File: rtl/burst_addr_step.sv
// Combinational next-address stepper.
// Computes the address of the following beat from the current one.
// Assumes that in wrap mode the current address lies inside the window
// described by wrap_mask (window size minus one, a power of two minus one).
module burst_addr_step
    import burst_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 3
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [SW-1:0] size,
    input  step_e         mode,
    input  logic [AW-1:0] wrap_mask,
    output logic [AW-1:0] next_addr
);
    logic [AW-1:0] stride;
    logic [AW-1:0] linear_sum;

    // Stride and straight sum shared by the linear and wrap modes.
    always_comb begin
        stride     = AW'(1) << size;
        linear_sum = cur_addr + stride;
    end

    // Select the step rule: hold, straight add, or add inside the window.
    always_comb begin
        unique case (mode)
            STEP_HOLD:   next_addr = cur_addr;
            STEP_WRAP:   next_addr = (cur_addr & ~wrap_mask) | (linear_sum & wrap_mask);
            default:     next_addr = linear_sum;
        endcase
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat sequencer: tracks whether a burst is in progress and how many
// beats remain. A load in the same cycle as the final step starts the
// next burst directly. Assumes step is only asserted while busy.
module burst_beat_ctrl #(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] len_in,
    input  logic          step,
    output logic          busy,
    output logic          last
);
    logic [LW-1:0] remain;

    // Busy flag and remaining-beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            remain <= len_in;
        end else if (step) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - LW'(1);
            end
        end
    end

    // Final beat is the one presented while no further beats remain.
    always_comb begin
        last = busy && (remain == '0);
    end
endmodule

// File: rtl/axi_burst_expander.sv
// Burst-to-beat address expander, top level.
// Captures one burst command per handshake and emits len+1 beats with
// per-beat addresses under fixed, incrementing or wrapping rules.
// Assumes an upstream that holds its command stable while in_valid is
// high and in_ready is low. No 4 KB boundary check is applied.
module axi_burst_expander
    import burst_pkg::*;
#(
    parameter int AW  = 32,
    parameter int IDW = 4,
    parameter int LW  = 8,
    parameter int SW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [AW-1:0]  in_addr,
    input  logic [1:0]     in_burst,
    input  logic [LW-1:0]  in_len,
    input  logic [SW-1:0]  in_size,
    input  logic [IDW-1:0] in_id,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [AW-1:0]  out_addr,
    output logic [1:0]     out_burst,
    output logic [LW-1:0]  out_len,
    output logic [SW-1:0]  out_size,
    output logic [IDW-1:0] out_id,
    output logic           out_last,
    output logic           out_wrap_err
);
    localparam int MAX_WRAP_BEATS = 16;

    logic           busy;
    logic           last_beat;
    logic           accept;
    logic           step;
    logic [AW-1:0]  cur_addr;
    logic [AW-1:0]  next_addr;
    logic [AW-1:0]  wrap_mask_d;
    logic [AW-1:0]  wrap_mask_q;
    logic [AW-1:0]  align_mask;
    logic           len_ok;
    logic           wrap_ok;
    logic           err_d;
    logic           err_q;
    step_e          mode_d;
    step_e          mode_q;
    logic [1:0]     burst_q;
    logic [LW-1:0]  len_q;
    logic [SW-1:0]  size_q;
    logic [IDW-1:0] id_q;

    // Handshake glue: the next command enters with the final beat.
    always_comb begin
        step     = busy && out_ready;
        in_ready = !busy || (out_ready && last_beat);
        accept   = in_valid && in_ready;
    end

    // Decode the incoming command into a step mode, window mask and error.
    always_comb begin
        wrap_mask_d = ((AW'(in_len) + AW'(1)) << in_size) - AW'(1);
        align_mask  = (AW'(1) << in_size) - AW'(1);
        len_ok      = 1'b0;
        for (int n = 2; n <= MAX_WRAP_BEATS; n = n * 2) begin
            if (in_len == LW'(n - 1)) len_ok = 1'b1;
        end
        wrap_ok = len_ok && ((in_addr & align_mask) == '0);
        err_d   = 1'b0;
        unique case (burst_e'(in_burst))
            BT_FIXED: mode_d = STEP_HOLD;
            BT_WRAP: begin
                mode_d = wrap_ok ? STEP_WRAP : STEP_LINEAR;
                err_d  = !wrap_ok;
            end
            default:  mode_d = STEP_LINEAR;
        endcase
    end

    // Command register, loaded on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_mask_q <= '0;
            err_q       <= 1'b0;
            mode_q      <= STEP_HOLD;
            burst_q     <= '0;
            len_q       <= '0;
            size_q      <= '0;
            id_q        <= '0;
        end else if (accept) begin
            wrap_mask_q <= wrap_mask_d;
            err_q       <= err_d;
            mode_q      <= mode_d;
            burst_q     <= in_burst;
            len_q       <= in_len;
            size_q      <= in_size;
            id_q        <= in_id;
        end
    end

    // Current beat address: start on acceptance, stepped per consumed beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (accept) begin
            cur_addr <= in_addr;
        end else if (step) begin
            cur_addr <= next_addr;
        end
    end

    burst_addr_step #(
        .AW (AW),
        .SW (SW)
    ) u_step (
        .cur_addr  (cur_addr),
        .size      (size_q),
        .mode      (mode_q),
        .wrap_mask (wrap_mask_q),
        .next_addr (next_addr)
    );

    burst_beat_ctrl #(
        .LW (LW)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .len_in (in_len),
        .step   (step),
        .busy   (busy),
        .last   (last_beat)
    );

    // Output beat fields.
    always_comb begin
        out_valid    = busy;
        out_addr     = cur_addr;
        out_burst    = burst_q;
        out_len      = len_q;
        out_size     = size_q;
        out_id       = id_q;
        out_last     = last_beat;
        out_wrap_err = busy && err_q;
    end
endmodule

// File: rtl/burst_expander_checks.sv
// Protocol checker for the burst address expander, attached by bind.
// Observes the top-level ports only.
module burst_expander_checks #(
    parameter int AW  = 32,
    parameter int IDW = 4,
    parameter int LW  = 8,
    parameter int SW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [AW-1:0]  in_addr,
    input logic [IDW-1:0] in_id,
    input logic           out_valid,
    input logic           out_ready,
    input logic [AW-1:0]  out_addr,
    input logic [1:0]     out_burst,
    input logic [IDW-1:0] out_id,
    input logic           out_last,
    input logic           out_wrap_err
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && in_ready));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_addr == $past(in_addr) && out_id == $past(in_id)));

    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_fixed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last && out_burst == 2'd0) |=> (out_addr == $past(out_addr)));

    assert_err_only_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_wrap_err |-> (out_valid && out_burst == 2'd2));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_last) && $stable(out_id)));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !(out_ready && out_last)) |-> !in_ready);
endmodule

bind axi_burst_expander burst_expander_checks #(
    .AW  (AW),
    .IDW (IDW),
    .LW  (LW),
    .SW  (SW)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_addr      (in_addr),
    .in_id        (in_id),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_addr     (out_addr),
    .out_burst    (out_burst),
    .out_id       (out_id),
    .out_last     (out_last),
    .out_wrap_err (out_wrap_err)
);

// File: tb/axi_burst_expander_test.sv
// Directed bench for the burst address expander.
module axi_burst_expander_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [1:0]  in_burst = '0;
    logic [7:0]  in_len = '0;
    logic [2:0]  in_size = '0;
    logic [3:0]  in_id = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic [1:0]  out_burst;
    logic [7:0]  out_len;
    logic [2:0]  out_size;
    logic [3:0]  out_id;
    logic        out_last;
    logic        out_wrap_err;

    int tests_run = 0;
    int tests_failed = 0;
    int cycle = 0;
    int unsigned seed = 32'h1234_5678;
    int accept_cyc;
    int last_cyc;

    axi_burst_expander uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_burst(in_burst), .in_len(in_len), .in_size(in_size), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_burst(out_burst), .out_len(out_len), .out_size(out_size),
        .out_id(out_id), .out_last(out_last), .out_wrap_err(out_wrap_err)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic bit wrap_legal(input logic [31:0] a, input int len, input int size);
        longint bytes = longint'(1) << size;
        return (len == 1 || len == 3 || len == 7 || len == 15) && ((longint'(a) % bytes) == 0);
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int bt,
                                             input int len, input int size, input int i);
        longint bytes = longint'(1) << size;
        longint win;
        longint base;
        if (bt == 0) return a;
        if (bt == 2 && wrap_legal(a, len, size)) begin
            win  = longint'(len + 1) * bytes;
            base = longint'(a) - (longint'(a) % win);
            return 32'(base + ((longint'(a) % win) + longint'(i) * bytes) % win);
        end
        return 32'(longint'(a) + longint'(i) * bytes);
    endfunction

    // Offers one command after some idle cycles; records its acceptance cycle.
    task automatic produce(input logic [31:0] a, input int bt, input int len,
                           input int size, input int id, input int idle);
        repeat (idle) @(posedge clk);
        @(posedge clk); #1;
        in_valid = 1'b1; in_addr = a; in_burst = 2'(bt);
        in_len = 8'(len); in_size = 3'(size); in_id = 4'(id);
        forever begin
            @(negedge clk); #2;
            if (in_ready) begin
                accept_cyc = cycle;
                @(posedge clk); #1;
                in_valid = 1'b0; in_addr = 32'hDEAD_BEEF; in_id = 4'hF;
                break;
            end
        end
    endtask

    // Consumes one burst with random stalls, checking every beat.
    task automatic consume(input logic [31:0] a, input int bt, input int len,
                           input int size, input int id, input int stall);
        bit exp_err = (bt == 2) && !wrap_legal(a, len, size);
        string areq = (bt == 0) ? "R4" : (bt == 2 && !exp_err) ? "R6" : (exp_err ? "R7" : "R5");
        for (int i = 0; i <= len; i++) begin
            bit held = 1'b0;
            logic [31:0] held_addr = '0;
            forever begin
                @(negedge clk);
                out_ready = (rnd() % 100) >= stall;
                #1;
                if (out_valid && out_ready) break;
                if (out_valid && !held) begin
                    held = 1'b1;
                    held_addr = out_addr;
                end
            end
            if (held) check(out_addr == held_addr, "R8", "stalled beat changed", out_addr, held_addr);
            check(out_addr == exp_addr(a, bt, len, size, i), areq, $sformatf("beat %0d address", i),
                  out_addr, exp_addr(a, bt, len, size, i));
            check(out_last == (i == len), "R3", $sformatf("last flag beat %0d", i),
                  32'(out_last), 32'(i == len));
            check(out_wrap_err == exp_err, "R7", "wrap error flag", 32'(out_wrap_err), 32'(exp_err));
            if (i == 0 || i == len)
                check(out_id == 4'(id) && out_burst == 2'(bt) && out_len == 8'(len) && out_size == 3'(size),
                      "R10", "copied fields", {out_id, out_burst, out_len, out_size, 15'd0},
                      {4'(id), 2'(bt), 8'(len), 3'(size), 15'd0});
            last_cyc = cycle;
        end
    endtask

    // Confirms the burst ended with no extra beat and the input is open again.
    task automatic check_drained(input string tag);
        @(negedge clk); out_ready = 1'b1; #1;
        check(!out_valid, "R3", {tag, ": beat after last"}, 32'(out_valid), 32'd0);
        check(in_ready, "R9", {tag, ": ready when idle"}, 32'(in_ready), 32'd1);
        out_ready = 1'b0;
    endtask

    task automatic run_burst(input string tag, input logic [31:0] a, input int bt,
                             input int len, input int size, input int id, input int stall);
        fork
            produce(a, bt, len, size, id, rnd() % 3);
            consume(a, bt, len, size, id, stall);
        join
        check(last_cyc > accept_cyc, "R2", {tag, ": first beat after acceptance"},
              32'(last_cyc), 32'(accept_cyc + 1));
        check_drained(tag);
    endtask

    task automatic test_reset();
        @(negedge clk); #1;
        check(!out_valid, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    endtask

    task automatic test_back_to_back();
        int first_last;
        fork
            begin
                produce(32'h0000_2000, 1, 7, 2, 3, 0);
                produce(32'h0000_3008, 2, 3, 3, 9, 0);
            end
            begin
                consume(32'h0000_2000, 1, 7, 2, 3, 40);
                first_last = last_cyc;
                consume(32'h0000_3008, 2, 3, 3, 9, 40);
            end
        join
        check(accept_cyc == first_last, "R9", "queued command accept cycle",
              32'(accept_cyc), 32'(first_last));
        check_drained("back-to-back");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        run_burst("fixed",        32'h1234_5670, 0, 5,   2, 1,  0);
        run_burst("incr",         32'h0000_0100, 1, 9,   2, 2,  50);
        run_burst("incr long",    32'h7FFF_FF80, 1, 255, 0, 5,  30);
        run_burst("incr rollover",32'hFFFF_FFF8, 1, 3,   2, 6,  20);
        run_burst("code3",        32'h0000_0040, 3, 3,   3, 7,  10);
        run_burst("wrap small",   32'h0000_0004, 2, 3,   1, 8,  0);
        run_burst("wrap wide",    32'h8000_0160, 2, 3,   4, 10, 50);
        run_burst("wrap 16",      32'h1000_003C, 2, 15,  2, 11, 60);
        run_burst("wrap badlen",  32'h0000_0200, 2, 2,   2, 12, 20);
        run_burst("wrap misalign",32'h0000_0102, 2, 3,   2, 13, 20);
        test_back_to_back();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests_failed++;
        tests_run++;
        $display("FAIL R3 watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule